// File: doc/BRIEF.md
# DRAM Strobe-Order Cycle Decoder

This block plays the device side of an asynchronous DRAM with multiplexed addressing. The active-low strobes (row strobe, column strobe, write enable, output enable) are sampled on every edge of a fast system clock. The block decides what each row-strobe cycle is from the order in which the strobes change around the row-strobe fall. No command code is involved. It is meant for memory models and device emulators that have to be checked cycle by cycle against a controller.

A row-strobe fall with the column strobe already low starts a refresh. The row for that refresh comes from an internal counter. If write enable is also low at that fall, the cycle enters a sticky test mode. A row-strobe fall with the column strobe high opens a row. Each later column-strobe fall inside that row is an access:
- a read, when write enable is high at the column fall;
- an early write, when write enable is already low;
- a read-modify-write, when write enable falls later while the column strobe is still low.

A row cycle that ends with no column access is a row-only refresh. The block holds a small word array so that read data can be checked. In test mode, a read reports whether two neighbouring words agree instead of returning the stored word.

At the end of every row cycle the block reports the cycle's class and row for one clock. It raises a one-clock error pulse when write enable moves at a time that would leave the output undefined.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, dout_en, cyc_valid, test_mode and proto_err are 0, and the refresh counter is 0.
- R2: A row-strobe fall with cas_n low starts a refresh. At the row-strobe rise, cyc_valid pulses for one clock with cyc_type 5, or 6 when the cycle enters test mode. cyc_row carries the counter value, and the counter then advances by one, wrapping modulo 2^AW. A row-strobe fall with cas_n low right after an access cycle (column strobe held low) is also such a refresh.
- R3: A refresh started with we_n low sets test_mode from the clock after the row-strobe fall. It reports type 6 and also advances the counter.
- R4: test_mode is cleared by a refresh started with we_n high (from the row-strobe fall) or by a row-only refresh (from its row-strobe rise). A row-only refresh is a row cycle with no column-strobe fall. It reports type 4, with cyc_row equal to the address latched at the row-strobe fall.
- R5: A read is a column-strobe fall with we_n high. dout takes the word at index {row[ROW_B-1:0], col[COL_B-1:0]} in the clock after that fall. dout_en is 1 while the column strobe and oe_n are low. The cycle reports type 1 with the row address.
- R6: An early write is a column-strobe fall with we_n already low. It stores din and keeps dout_en at 0 for the whole access, even with oe_n low. The cycle reports type 2.
- R7: A read-modify-write is a we_n fall at least CWD_MIN samples after the column-strobe fall. dout keeps the old word, and din is stored. The cycle reports type 3.
- R8: proto_err pulses for one clock in three cases: a read-modify-write whose we_n fall comes fewer than CWD_MIN samples after the column-strobe fall; a read-modify-write whose we_n fall comes while oe_n is low; a we_n rise while the column strobe is still low in an early write.
- R9: In test mode, a read returns all zeros when the words at the selected index with column bit 0 forced to 0 and to 1 are equal, and all ones otherwise.
- R10: Several column-strobe cycles inside one row cycle are each performed. The class reported at the row-strobe rise is that of the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_en | output | 1 | Output driver enable |
| cyc_valid | output | 1 | One-clock pulse at the end of a row cycle |
| cyc_type | output | 3 | 1 read, 2 early write, 3 read-modify-write, 4 row-only, 5 refresh, 6 test entry |
| cyc_row | output | AW | Row used by the finished cycle |
| test_mode | output | 1 | Sticky test-mode flag |
| proto_err | output | 1 | Write-enable timing error pulse |

## Verification
The assertions check the following on every clock:
- a refresh report agrees with the counter that just advanced;
- test entry and test exit leave the flag in the right state;
- the output driver is never on outside a row cycle or during an early write;
- error pulses stay one clock wide.

Whether each strobe ordering lands in the right class, and whether stored and compared data are correct, can only be shown by the bench's scenarios. These cover early, delayed and late write-enable edges, page bursts, hidden refresh and a full wrap of the refresh counter.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [2:0] {
    CYC_NONE   = 3'd0,
    CYC_READ   = 3'd1,
    CYC_EWRITE = 3'd2,
    CYC_RMW    = 3'd3,
    CYC_RONLY  = 3'd4,
    CYC_CBR    = 3'd5,
    CYC_TEST   = 3'd6
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CBR, ST_ROW, ST_READ, ST_EWR, ST_RMW
  } st_e;
endpackage

// File: rtl/dram_strobe_edges.sv
module dram_strobe_edges #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_n;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall[i] =  prev_q[i] & ~lvl_n[i];
    assign rise[i] = ~prev_q[i] &  lvl_n[i];
  end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int DW    = 4,
  parameter int ROW_B = 2,
  parameter int COL_B = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             cap,
  input  logic             test,
  input  logic [ROW_B-1:0] row_idx,
  input  logic [COL_B-1:0] col_idx,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    rd_q
);
  localparam int IW    = ROW_B + COL_B;
  localparam int DEPTH = 1 << IW;
  localparam logic [IW-1:0] BIT0 = IW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx, idx_lo, idx_hi;

  // test-mode compare: zero when the pair agrees
  function automatic logic [DW-1:0] fold_cmp(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a == b) ? '0 : '1;
  endfunction

  assign idx    = {row_idx, col_idx};
  assign idx_lo = idx & ~BIT0;
  assign idx_hi = idx |  BIT0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr)  mem[idx] <= din;
      if (cap) rd_q <= test ? fold_cmp(mem[idx_lo], mem[idx_hi]) : mem[idx];
    end
  end
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_dec_pkg::*;
#(
  parameter int AW      = 10,
  parameter int ROW_B   = 2,
  parameter int COL_B   = 2,
  parameter int CWD_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_fall,
  input  logic             cas_rise,
  input  logic             we_fall,
  input  logic             we_rise,
  input  logic [AW-1:0]    addr,
  output logic [ROW_B-1:0] row_idx,
  output logic [COL_B-1:0] col_idx,
  output logic             mem_wr,
  output logic             rd_cap,
  output logic             test_mode,
  output logic             dout_en,
  output logic             cyc_valid,
  output logic [2:0]       cyc_type,
  output logic [AW-1:0]    cyc_row,
  output logic             proto_err
);
  localparam int CW = $clog2(CWD_MIN + 1);
  localparam logic [CW-1:0] CWD_LIM = CW'(CWD_MIN);

  st_e             st_q, st_d;
  cyc_e            cls_q;
  logic [AW-1:0]   ref_cnt, hold_q;
  logic [ROW_B-1:0] row_q;
  logic [COL_B-1:0] col_q;
  logic [CW-1:0]   cwd_q;

  // named internal events
  logic cbr_start, row_start, acc_rd, acc_ewr, acc_rmw, ewr_we_rise, cyc_end, wr_bad;

  function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic wr_too_early(input logic [CW-1:0] cnt);
    return cnt < CWD_LIM;
  endfunction

  assign cbr_start   = (st_q == ST_IDLE) & ras_fall & ~cas_n;
  assign row_start   = (st_q == ST_IDLE) & ras_fall &  cas_n;
  assign acc_rd      = (st_q == ST_ROW)  & ~ras_rise & cas_fall &  we_n;
  assign acc_ewr     = (st_q == ST_ROW)  & ~ras_rise & cas_fall & ~we_n;
  assign acc_rmw     = (st_q == ST_READ) & ~ras_rise & ~cas_rise & we_fall;
  assign ewr_we_rise = (st_q == ST_EWR)  & ~ras_rise & ~cas_rise & we_rise;
  assign cyc_end     = (st_q != ST_IDLE) & ras_rise;
  assign wr_bad      = acc_rmw & (wr_too_early(cwd_q) | ~oe_n);

  assign mem_wr  = acc_ewr | acc_rmw;
  assign rd_cap  = acc_rd;
  assign row_idx = row_q;
  assign col_idx = (acc_rd | acc_ewr) ? addr[COL_B-1:0] : col_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (cbr_start) st_d = ST_CBR;
               else if (row_start) st_d = ST_ROW;
      ST_CBR:  if (ras_rise) st_d = ST_IDLE;
      ST_ROW:  if (ras_rise) st_d = ST_IDLE;
               else if (cas_fall) st_d = we_n ? ST_READ : ST_EWR;
      ST_READ: if (ras_rise) st_d = ST_IDLE;
               else if (cas_rise) st_d = ST_ROW;
               else if (we_fall) st_d = ST_RMW;
      default: if (ras_rise) st_d = ST_IDLE;
               else if (cas_rise) st_d = ST_ROW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cls_q     <= CYC_NONE;
      ref_cnt   <= '0;
      hold_q    <= '0;
      row_q     <= '0;
      col_q     <= '0;
      cwd_q     <= '0;
      test_mode <= 1'b0;
      dout_en   <= 1'b0;
      cyc_valid <= 1'b0;
      cyc_type  <= 3'd0;
      cyc_row   <= '0;
      proto_err <= 1'b0;
    end else begin
      st_q      <= st_d;
      dout_en   <= ((st_d == ST_READ) | (st_d == ST_RMW)) & ~oe_n & ~cas_n;
      proto_err <= wr_bad | ewr_we_rise;
      cyc_valid <= cyc_end;
      if (cbr_start) begin
        cls_q     <= we_n ? CYC_CBR : CYC_TEST;
        hold_q    <= ref_cnt;
        ref_cnt   <= ref_next(ref_cnt);
        test_mode <= ~we_n;
      end
      if (row_start) begin
        cls_q  <= CYC_RONLY;
        hold_q <= addr;
        row_q  <= addr[ROW_B-1:0];
      end
      if (acc_rd | acc_ewr) begin
        cls_q <= acc_rd ? CYC_READ : CYC_EWRITE;
        col_q <= addr[COL_B-1:0];
        cwd_q <= CW'(1);
      end else if ((st_q == ST_READ) && wr_too_early(cwd_q)) begin
        cwd_q <= cwd_q + 1'b1;
      end
      if (acc_rmw) cls_q <= CYC_RMW;
      if (cyc_end) begin
        cyc_type <= cls_q;
        cyc_row  <= hold_q;
        if (cls_q == CYC_RONLY) test_mode <= 1'b0;
      end
    end
  end

  // R2
  cbr_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && (cyc_type == CYC_CBR || cyc_type == CYC_TEST) |-> (cyc_row + 1'b1) == ref_cnt);
  // R3
  test_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_type == CYC_TEST |-> test_mode);
  // R4
  test_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && (cyc_type == CYC_RONLY || cyc_type == CYC_CBR) |-> !test_mode);
  // R6
  ewr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EWR) |-> !dout_en);
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder #(
  parameter int AW      = 10,
  parameter int DW      = 4,
  parameter int ROW_B   = 2,
  parameter int COL_B   = 2,
  parameter int CWD_MIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          cyc_valid,
  output logic [2:0]    cyc_type,
  output logic [AW-1:0] cyc_row,
  output logic          test_mode,
  output logic          proto_err
);
  logic [2:0]       fall, rise;
  logic [ROW_B-1:0] row_idx;
  logic [COL_B-1:0] col_idx;
  logic             mem_wr, rd_cap;

  dram_strobe_edges #(.N(3)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl_n({we_n, cas_n, ras_n}), .fall(fall), .rise(rise)
  );

  dram_cycle_ctrl #(.AW(AW), .ROW_B(ROW_B), .COL_B(COL_B), .CWD_MIN(CWD_MIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .ras_fall(fall[0]), .ras_rise(rise[0]), .cas_fall(fall[1]), .cas_rise(rise[1]),
    .we_fall(fall[2]), .we_rise(rise[2]), .addr(addr),
    .row_idx(row_idx), .col_idx(col_idx), .mem_wr(mem_wr), .rd_cap(rd_cap),
    .test_mode(test_mode), .dout_en(dout_en), .cyc_valid(cyc_valid),
    .cyc_type(cyc_type), .cyc_row(cyc_row), .proto_err(proto_err)
  );

  dram_cell_array #(.DW(DW), .ROW_B(ROW_B), .COL_B(COL_B)) u_array (
    .clk(clk), .rst_n(rst_n), .wr(mem_wr), .cap(rd_cap), .test(test_mode),
    .row_idx(row_idx), .col_idx(col_idx), .din(din), .rd_q(dout)
  );

  // R5
  drive_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !$past(ras_n));
endmodule

// File: tb/test_dram_strobe_decoder.sv
module test_dram_strobe_decoder;
  localparam int AW = 10, DW = 4, CWD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, cyc_valid, test_mode, proto_err;
  logic [2:0] cyc_type;
  logic [AW-1:0] cyc_row;

  dram_strobe_decoder i_dram_strobe_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .cyc_valid(cyc_valid),
    .cyc_type(cyc_type), .cyc_row(cyc_row), .test_mode(test_mode), .proto_err(proto_err)
  );

  always #4 clk = ~clk;

  typedef struct { logic [2:0] t; logic [AW-1:0] row; int req; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] bm [16];
  logic [AW-1:0] bref = '0;
  bit tm = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] bench_read(input logic [1:0] r, input logic [1:0] c);
    logic [3:0] i;
    i = {r, c};
    if (tm) return (bm[{i[3:1], 1'b0}] == bm[{i[3:1], 1'b1}]) ? 4'h0 : 4'hF;
    return bm[i];
  endfunction

  task automatic push(input logic [2:0] t, input logic [AW-1:0] row, input int req);
    exp_t e;
    e.t = t; e.row = row; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: pop expected cycle reports
  always @(negedge clk) begin
    if (rst_n && cyc_valid) begin
      if (sb.size() == 0) chk("R2 unexpected report", 32'(cyc_type), 32'hFF);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk($sformatf("R%0d cyc_type", e.req), 32'(cyc_type), 32'(e.t));
        chk($sformatf("R%0d cyc_row", e.req), 32'(cyc_row), 32'(e.row));
      end
    end
  end

  task automatic release_all();
    ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic do_read(input logic [AW-1:0] row, input logic [AW-1:0] col, input bit hidden);
    logic [DW-1:0] e;
    ras_n = 0; addr = row; @(negedge clk);
    addr = col; cas_n = 0; oe_n = 0; @(negedge clk);
    e = bench_read(row[1:0], col[1:0]);
    chk(tm ? "R9 test read" : "R5 read data", 32'(dout), 32'(e));
    chk("R5 dout_en on", 32'(dout_en), 32'd1);
    push(3'd1, row, 5);
    if (hidden) begin
      ras_n = 1; @(negedge clk);
      ras_n = 0; @(negedge clk);
      push(we_n ? 3'd5 : 3'd6, bref, 2);
      bref = bref + 1'b1;
    end
    release_all(); @(negedge clk); @(negedge clk);
  endtask

  task automatic do_ewrite(input logic [AW-1:0] row, input logic [AW-1:0] col, input logic [DW-1:0] d);
    ras_n = 0; addr = row; @(negedge clk);
    addr = col; din = d; we_n = 0; oe_n = 0; cas_n = 0; @(negedge clk);
    chk("R6 early write hi-z", 32'(dout_en), 32'd0);
    @(negedge clk);
    chk("R6 early write hi-z later", 32'(dout_en), 32'd0);
    bm[{row[1:0], col[1:0]}] = d;
    push(3'd2, row, 6);
    release_all(); @(negedge clk); @(negedge clk);
  endtask

  task automatic do_rmw(input logic [AW-1:0] row, input logic [AW-1:0] col, input logic [DW-1:0] d,
                        input int dly, input bit oe_on);
    logic [DW-1:0] old;
    ras_n = 0; addr = row; @(negedge clk);
    addr = col; cas_n = 0; oe_n = 0; @(negedge clk);
    old = bench_read(row[1:0], col[1:0]);
    chk("R7 rmw read phase", 32'(dout), 32'(old));
    if (!oe_on) oe_n = 1;
    repeat (dly - 1) @(negedge clk);
    we_n = 0; din = d; @(negedge clk);
    chk("R8 proto_err", 32'(proto_err), 32'((dly < CWD) || oe_on));
    chk("R7 rmw keeps old data", 32'(dout), 32'(old));
    @(negedge clk);
    chk("R8 proto_err pulse ends", 32'(proto_err), 32'd0);
    bm[{row[1:0], col[1:0]}] = d;
    push(3'd3, row, 7);
    release_all(); @(negedge clk); @(negedge clk);
  endtask

  task automatic do_cbr(input bit we_low);
    cas_n = 0; we_n = !we_low; @(negedge clk);
    ras_n = 0; @(negedge clk);
    chk(we_low ? "R3 test entry" : "R4 exit by refresh", 32'(test_mode), 32'(we_low));
    push(we_low ? 3'd6 : 3'd5, bref, we_low ? 3 : 2);
    bref = bref + 1'b1;
    tm = we_low;
    release_all(); @(negedge clk); @(negedge clk);
  endtask

  task automatic do_ronly(input logic [AW-1:0] row);
    ras_n = 0; addr = row; @(negedge clk); @(negedge clk);
    push(3'd4, row, 4);
    tm = 0;
    ras_n = 1; @(negedge clk);
    chk("R4 exit by row-only", 32'(test_mode), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) bm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R1 dout_en", 32'(dout_en), 32'd0);
    chk("R1 cyc_valid", 32'(cyc_valid), 32'd0);
    chk("R1 test_mode", 32'(test_mode), 32'd0);
    chk("R1 proto_err", 32'(proto_err), 32'd0);

    do_cbr(0);                        // R1: counter starts at 0
    do_ewrite(10'h101, 10'h002, 4'h9);
    do_ewrite(10'h002, 10'h003, 4'h6);
    do_read(10'h101, 10'h002, 0);
    do_read(10'h002, 10'h003, 0);
    do_rmw(10'h101, 10'h002, 4'h3, CWD, 0);
    do_read(10'h101, 10'h002, 0);
    do_rmw(10'h002, 10'h003, 4'hC, 1, 0);   // too early
    do_rmw(10'h002, 10'h003, 4'h5, CWD + 1, 1); // OE still on
    do_ronly(10'h3A5);
    do_read(10'h002, 10'h003, 1);           // hidden refresh

    // R8: we rise during early write
    ras_n = 0; addr = 10'h001; @(negedge clk);
    addr = 10'h000; din = 4'h7; we_n = 0; cas_n = 0; @(negedge clk);
    we_n = 1; @(negedge clk);
    chk("R8 we rise in early write", 32'(proto_err), 32'd1);
    bm[4'b0100] = 4'h7;
    push(3'd2, 10'h001, 8);
    release_all(); @(negedge clk); @(negedge clk);

    // R10: page burst read, read, early write
    ras_n = 0; addr = 10'h003; @(negedge clk);
    addr = 10'h001; cas_n = 0; oe_n = 0; @(negedge clk);
    chk("R10 page read 1", 32'(dout), 32'(bm[4'b1101]));
    cas_n = 1; @(negedge clk);
    addr = 10'h002; cas_n = 0; @(negedge clk);
    chk("R10 page read 2", 32'(dout), 32'(bm[4'b1110]));
    cas_n = 1; @(negedge clk);
    addr = 10'h000; din = 4'hB; we_n = 0; cas_n = 0; @(negedge clk);
    chk("R10 page write hi-z", 32'(dout_en), 32'd0);
    bm[4'b1100] = 4'hB;
    push(3'd2, 10'h003, 10);
    release_all(); @(negedge clk); @(negedge clk);
    do_read(10'h003, 10'h000, 0);

    // R9: test mode compare
    do_ewrite(10'h000, 10'h000, 4'h5);
    do_ewrite(10'h000, 10'h001, 4'h5);
    do_cbr(1);
    do_read(10'h000, 10'h000, 0);         // equal -> 0
    do_ewrite(10'h000, 10'h001, 4'hA);
    do_read(10'h000, 10'h001, 0);         // differ -> F
    do_cbr(1);                            // stays in test
    do_cbr(0);                            // exit
    do_read(10'h000, 10'h001, 0);
    do_cbr(1);
    do_ronly(10'h000);
    do_read(10'h000, 10'h000, 0);

    // R2: wrap the refresh counter
    for (int k = 0; k < 1030; k++) do_cbr(0);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 32'(sb.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule